// File: doc/BRIEF.md
# PTP Residence Time Corrector

This block measures how long each precision-time event frame stays inside a switch and folds that delay into the frame's 64-bit correction value as the frame leaves. When a frame's start-of-frame passes the ingress MAC boundary, the current value of the switch's 48-bit nanosecond time-of-day counter is stored in a slot chosen by the frame's tag. The frame then waits in the switch queues for however long congestion dictates. When it reaches the egress MAC boundary, the time counter is sampled again and the stored value for the same tag is subtracted from it. Two fixed latencies are added to the difference. These latencies account for the path between each PHY and its sampling point. The sum is converted to correction units (nanoseconds scaled by 2^16) and added to the incoming correction value.

Because the delay is measured for each frame in hardware and carried with the frame, time spent in queues is corrected out rather than showing up downstream as clock drift. Up to sixteen frames may be in flight at once, and they may leave in any order. An egress frame whose tag has no stored timestamp is flagged as an error, and its correction value is passed through unchanged.

The egress side is a three-state machine. **IDLE** waits for an egress start-of-frame and captures the tag, the egress time and the incoming correction; this is the *accept* transition to CALC. **CALC** reads the tag slot, forms the new correction (or the pass-through value on a miss) and releases the slot; it always takes the *compute* transition to EMIT. **EMIT** presents the result with a one-cycle valid pulse and always takes the *return* transition to IDLE.

Top module: `rtc_corrector`

## Requirements
- R1: After reset, egr_valid and egr_err are 0 and every tag slot is empty, so a first egress on any tag reports an error.
- R2: A high ing_sof stores the tod_ns value present at that clock edge in the slot selected by ing_tag, and marks the slot full.
- R3: For an egress on a full slot, egr_corr_out = (egr_corr_in + (R << 16)) mod 2^64. Here R = (t2 - t1 + cfg_ing_lat + cfg_egr_lat) mod 2^48, t1 is the stored time and t2 is tod_ns at the edge that samples egr_sof. egr_err is 0 in this case.
- R4: A wrap of the 48-bit time counter between t1 and t2 still yields the correct residence time, because the subtraction is taken modulo 2^48.
- R5: The values of cfg_ing_lat and cfg_egr_lat, in nanoseconds, are added to the residence time of every frame.
- R6: egr_valid is high for exactly one cycle. That cycle starts at the second rising edge after the edge that samples egr_sof in IDLE.
- R7: An egress on an empty slot gives egr_err = 1 together with egr_valid, and egr_corr_out equals egr_corr_in unchanged.
- R8: Each egress frees its slot, so a second egress on the same tag without a new ingress reports an error.
- R9: All 16 tags (ing_tag/egr_tag values 0 to 15) hold independent timestamps, and frames may leave in any order.
- R10: An egr_sof that arrives while the machine is in CALC or EMIT is ignored. It produces no output pulse and does not free any slot.
- R11: A second ingress on a tag that is already full overwrites the stored time with the newer sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tod_ns | input | 48 | Free-running nanosecond time counter |
| cfg_ing_lat | input | 16 | Fixed PHY-to-sample delay on ingress, ns |
| cfg_egr_lat | input | 16 | Fixed sample-to-PHY delay on egress, ns |
| ing_sof | input | 1 | Ingress start-of-frame strobe |
| ing_tag | input | 4 | Tag of the ingress frame |
| egr_sof | input | 1 | Egress start-of-frame strobe |
| egr_tag | input | 4 | Tag of the egress frame |
| egr_corr_in | input | 64 | Correction value carried by the egress frame |
| egr_valid | output | 1 | One-cycle pulse: result is present |
| egr_err | output | 1 | No stored timestamp for the egress tag |
| egr_corr_out | output | 64 | Updated correction value |

## Verification
A slot that holds a stale or wrong timestamp shows up as a wrong correction value at the very next egress on that tag, two edges after egr_sof. A slot that was not freed shows up on the following repeat egress as a missing error flag. A stuck or skipped state in the machine changes the position or width of the egr_valid pulse within three cycles. A back-to-back egress strobe exposes an IDLE check that leaks, because it produces an extra pulse or a slot that has vanished by its later egress.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_EMIT = 2'd2
    } rtc_state_e;

endpackage

// File: rtl/rtc_ts_store.sv
module rtc_ts_store #(
    parameter int TS_W  = 48,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TS_W-1:0]  wr_ts,
    input  logic             free_en,
    input  logic [TAG_W-1:0] free_tag,
    input  logic [TAG_W-1:0] rd_tag,
    output logic [TS_W-1:0]  rd_ts,
    output logic             rd_hit
);
    localparam int DEPTH = 1 << TAG_W;

    logic [TS_W-1:0] ts_q  [DEPTH];
    logic [DEPTH-1:0] full_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // A write on the same tag as a release wins: the new frame owns it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full_q[i] <= 1'b0;
            end else if (wr_en && (wr_tag == TAG_W'(i))) begin
                full_q[i] <= 1'b1;
            end else if (free_en && (free_tag == TAG_W'(i))) begin
                full_q[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_tag == TAG_W'(i))) begin
                ts_q[i] <= wr_ts;
            end
        end
    end

    assign rd_ts  = ts_q[rd_tag];
    assign rd_hit = full_q[rd_tag];

endmodule

// File: rtl/rtc_resid_calc.sv
module rtc_resid_calc #(
    parameter int TS_W   = 48,
    parameter int CORR_W = 64,
    parameter int FRAC_W = 16,
    parameter int LAT_W  = 16
) (
    input  logic [TS_W-1:0]   t_in,
    input  logic [TS_W-1:0]   t_out,
    input  logic [LAT_W-1:0]  lat_in,
    input  logic [LAT_W-1:0]  lat_out,
    input  logic [CORR_W-1:0] corr_in,
    output logic [CORR_W-1:0] corr_sum
);
    localparam int PAD_LAT = TS_W - LAT_W;
    localparam int PAD_RES = CORR_W - TS_W;

    logic [TS_W-1:0]   resid;
    logic [CORR_W-1:0] resid_scaled;

    // Truncation to TS_W bits makes the difference wrap-safe.
    always_comb begin
        resid = t_out - t_in
              + {{PAD_LAT{1'b0}}, lat_in}
              + {{PAD_LAT{1'b0}}, lat_out};
        resid_scaled = {{PAD_RES{1'b0}}, resid} << FRAC_W;
        corr_sum = corr_in + resid_scaled;
    end

endmodule

// File: rtl/rtc_corrector.sv
module rtc_corrector #(
    parameter int TS_W   = 48,
    parameter int CORR_W = 64,
    parameter int FRAC_W = 16,
    parameter int LAT_W  = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   tod_ns,
    input  logic [LAT_W-1:0]  cfg_ing_lat,
    input  logic [LAT_W-1:0]  cfg_egr_lat,
    input  logic              ing_sof,
    input  logic [TAG_W-1:0]  ing_tag,
    input  logic              egr_sof,
    input  logic [TAG_W-1:0]  egr_tag,
    input  logic [CORR_W-1:0] egr_corr_in,
    output logic              egr_valid,
    output logic              egr_err,
    output logic [CORR_W-1:0] egr_corr_out
);
    import rtc_pkg::*;

    rtc_state_e        state_q, state_d;
    logic [TAG_W-1:0]  tag_q;
    logic [TS_W-1:0]   t2_q;
    logic [CORR_W-1:0] cin_q;
    logic [CORR_W-1:0] corr_q;
    logic              miss_q;

    logic [TS_W-1:0]   t1_rd;
    logic              slot_hit;
    logic [CORR_W-1:0] corr_sum;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && egr_sof;

    rtc_ts_store #(.TS_W(TS_W), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ing_sof),
        .wr_tag   (ing_tag),
        .wr_ts    (tod_ns),
        .free_en  (state_q == ST_CALC),
        .free_tag (tag_q),
        .rd_tag   (tag_q),
        .rd_ts    (t1_rd),
        .rd_hit   (slot_hit)
    );

    rtc_resid_calc #(
        .TS_W(TS_W), .CORR_W(CORR_W), .FRAC_W(FRAC_W), .LAT_W(LAT_W)
    ) u_calc (
        .t_in     (t1_rd),
        .t_out    (t2_q),
        .lat_in   (cfg_ing_lat),
        .lat_out  (cfg_egr_lat),
        .corr_in  (cin_q),
        .corr_sum (corr_sum)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, compute, return
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (egr_sof) state_d = ST_CALC;
            ST_CALC: state_d = ST_EMIT;
            ST_EMIT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Data captured along the transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            t2_q   <= '0;
            cin_q  <= '0;
            corr_q <= '0;
            miss_q <= 1'b0;
        end else begin
            if (accept) begin
                tag_q <= egr_tag;
                t2_q  <= tod_ns;
                cin_q <= egr_corr_in;
            end
            if (state_q == ST_CALC) begin
                corr_q <= slot_hit ? corr_sum : cin_q;
                miss_q <= !slot_hit;
            end
        end
    end

    // Outputs
    always_comb begin
        egr_valid    = (state_q == ST_EMIT);
        egr_err      = (state_q == ST_EMIT) && miss_q;
        egr_corr_out = corr_q;
    end

endmodule

// File: rtl/rtc_corrector_chk.sv
module rtc_corrector_chk #(
    parameter int CORR_W = 64,
    parameter int FRAC_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              egr_sof,
    input logic [CORR_W-1:0] egr_corr_in,
    input logic              egr_valid,
    input logic              egr_err,
    input logic [CORR_W-1:0] egr_corr_out
);
    // R6: the result strobe never lasts two cycles
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        egr_valid |=> !egr_valid);

    // R6: every strobe was launched by a start-of-frame two edges earlier
    a_r6_launched_by_sof: assert property (@(posedge clk) disable iff (!rst_n)
        egr_valid |-> $past(egr_sof, 2));

    // R7: an error is only reported together with a result
    a_r7_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        egr_err |-> egr_valid);

    // R7: a miss passes the captured correction through untouched
    a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        egr_err |-> (egr_corr_out == $past(egr_corr_in, 2)));

    // R3: the scaled addition leaves the sub-nanosecond field untouched
    a_r3_frac_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (egr_valid && !egr_err) |->
            (egr_corr_out[FRAC_W-1:0] == $past(egr_corr_in[FRAC_W-1:0], 2)));

endmodule

bind rtc_corrector rtc_corrector_chk #(.CORR_W(CORR_W), .FRAC_W(FRAC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .egr_sof      (egr_sof),
    .egr_corr_in  (egr_corr_in),
    .egr_valid    (egr_valid),
    .egr_err      (egr_err),
    .egr_corr_out (egr_corr_out)
);

// File: tb/rtc_corrector_test.sv
`timescale 1ns/1ps
module rtc_corrector_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] tod_ns = '0;
    logic [15:0] cfg_ing_lat = '0;
    logic [15:0] cfg_egr_lat = '0;
    logic        ing_sof = 1'b0;
    logic [3:0]  ing_tag = '0;
    logic        egr_sof = 1'b0;
    logic [3:0]  egr_tag = '0;
    logic [63:0] egr_corr_in = '0;
    logic        egr_valid;
    logic        egr_err;
    logic [63:0] egr_corr_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic        got_v, got_e;
    logic [63:0] got_c;

    always #2.5 clk = ~clk;   // 200 MHz

    rtc_corrector uut (
        .clk(clk), .rst_n(rst_n), .tod_ns(tod_ns),
        .cfg_ing_lat(cfg_ing_lat), .cfg_egr_lat(cfg_egr_lat),
        .ing_sof(ing_sof), .ing_tag(ing_tag),
        .egr_sof(egr_sof), .egr_tag(egr_tag), .egr_corr_in(egr_corr_in),
        .egr_valid(egr_valid), .egr_err(egr_err), .egr_corr_out(egr_corr_out)
    );

    // Stimulus table: tag, t1, t2, incoming correction
    localparam int NV = 5;
    localparam logic [3:0]  V_TAG [NV] = '{4'd3, 4'd7, 4'd0, 4'd15, 4'd9};
    localparam logic [47:0] V_T1  [NV] = '{48'd1000, 48'h0000_1234_5678,
        48'hFFFF_FFFF_FF00, 48'd42, 48'd10};
    localparam logic [47:0] V_T2  [NV] = '{48'd1500, 48'h0000_1235_5678,
        48'h0000_0000_0080, 48'd42, 48'd11};
    localparam logic [63:0] V_CIN [NV] = '{64'd0, 64'h0000_0000_0000_ABCD,
        64'h0000_0000_0001_0000, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_0000};

    function automatic logic [63:0] expect_corr(input logic [47:0] t1, input logic [47:0] t2,
                                                input logic [15:0] li, input logic [15:0] le,
                                                input logic [63:0] cin);
        logic [47:0] r;
        r = t2 - t1 + {32'd0, li} + {32'd0, le};
        return cin + ({16'd0, r} << 16);
    endfunction

    task automatic chk64(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic ingress(input logic [3:0] tag, input logic [47:0] t);
        @(negedge clk);
        ing_sof = 1'b1; ing_tag = tag; tod_ns = t;
        @(negedge clk);
        ing_sof = 1'b0;
    endtask

    // Drives one egress, samples the pulse cycle, leaves the machine in IDLE.
    task automatic egress(input logic [3:0] tag, input logic [47:0] t, input logic [63:0] cin);
        @(negedge clk);
        egr_sof = 1'b1; egr_tag = tag; tod_ns = t; egr_corr_in = cin;
        @(negedge clk);
        egr_sof = 1'b0;
        @(negedge clk);
        got_v = egr_valid; got_e = egr_err; got_c = egr_corr_out;
        @(negedge clk);
        chk64("R6 pulse one cycle", {63'd0, egr_valid}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk64("R1 valid after reset", {63'd0, egr_valid}, 64'd0);
        chk64("R1 err after reset", {63'd0, egr_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R7: empty slot after reset
        egress(4'd5, 48'd777, 64'hDEAD_BEEF_0000_1111);
        chk64("R7 miss valid", {63'd0, got_v}, 64'd1);
        chk64("R1 R7 miss err", {63'd0, got_e}, 64'd1);
        chk64("R7 miss passthrough", got_c, 64'hDEAD_BEEF_0000_1111);

        // Table walk: R2 R3 R4 (vector 2 wraps the counter)
        for (int i = 0; i < NV; i++) begin
            ingress(V_TAG[i], V_T1[i]);
            egress(V_TAG[i], V_T2[i], V_CIN[i]);
            chk64("R6 valid in table", {63'd0, got_v}, 64'd1);
            chk64("R3 err clear", {63'd0, got_e}, 64'd0);
            chk64((i == 2) ? "R4 wrap correction" : "R2 R3 correction", got_c,
                  expect_corr(V_T1[i], V_T2[i], 16'd0, 16'd0, V_CIN[i]));
        end

        // R5 latency constants
        cfg_ing_lat = 16'd100; cfg_egr_lat = 16'd20;
        ingress(4'd2, 48'd5000);
        egress(4'd2, 48'd5300, 64'd0);
        chk64("R5 latency added", got_c, 64'd420 << 16);
        cfg_ing_lat = '0; cfg_egr_lat = '0;

        // R8 slot freed
        egress(4'd2, 48'd6000, 64'h55);
        chk64("R8 second egress err", {63'd0, got_e}, 64'd1);
        chk64("R8 second egress passthrough", got_c, 64'h55);

        // R9 all tags in flight, out of order
        for (int i = 0; i < 16; i++) ingress(4'(i), 48'(1000 * i + 7));
        for (int i = 15; i >= 0; i--) begin
            egress(4'(i), 48'(100000 + 13 * i), 64'(i));
            chk64("R9 in-flight err", {63'd0, got_e}, 64'd0);
            chk64("R9 in-flight correction", got_c,
                  expect_corr(48'(1000 * i + 7), 48'(100000 + 13 * i), 16'd0, 16'd0, 64'(i)));
        end

        // R10 egress strobe while busy is ignored
        ingress(4'd10, 48'd200);
        ingress(4'd11, 48'd300);
        @(negedge clk);
        egr_sof = 1'b1; egr_tag = 4'd10; tod_ns = 48'd260; egr_corr_in = 64'd0;
        @(negedge clk);
        egr_tag = 4'd11; tod_ns = 48'd400; egr_corr_in = 64'd9;
        @(negedge clk);
        egr_sof = 1'b0;
        chk64("R10 first result", egr_corr_out, 64'd60 << 16);
        @(negedge clk);
        chk64("R10 no extra pulse", {63'd0, egr_valid}, 64'd0);
        @(negedge clk);
        chk64("R10 still no pulse", {63'd0, egr_valid}, 64'd0);
        egress(4'd11, 48'd1300, 64'd0);
        chk64("R10 ignored tag kept", {63'd0, got_e}, 64'd0);
        chk64("R10 ignored tag value", got_c, 64'd1000 << 16);

        // R11 overwrite on reused tag
        ingress(4'd4, 48'd100);
        ingress(4'd4, 48'd300);
        egress(4'd4, 48'd500, 64'd0);
        chk64("R11 newer sample used", got_c, 64'd200 << 16);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule